// File: doc/BRIEF.md
# Serial Control Word Sender

This block sits on the host side of a three-wire control link to a digitally programmed audio equalizer. A controller presents an 8-bit parallel word and pulses a start input. The block captures the word and raises BUSY. It then sends the word one bit per period of a serial clock that it generates itself, starting with the least significant bit. The receiver samples each bit on the rising serial clock edge.

After the last bit, the block parks the serial clock low and drives DATA low. It then issues one latch pulse that tells the receiver to act on the word it has just shifted in. All serial timing comes from three system-clock counts: the half period, the gap before the latch, and the latch width. At elaboration the block checks these counts against the link limits: at least 1 µs for setup, hold, latch width and clock-to-latch delay, and a serial clock of at most 500 kHz.

The block does not interpret the word. An outside controller sends a band word and then a gain word, waiting for DONE or for BUSY to fall between them.

Top module: `eq_word_sender`

## Requirements
- R1: While reset is high and when idle, ser_clk_o, ser_data_o, ser_latch_o, busy_o and done_o are all low.
- R2: A start_i sampled high while idle captures word_i. Bit i of that word is on ser_data_o when the (i+1)-th rising edge of ser_clk_o occurs, bit 0 first.
- R3: Each transfer produces exactly WORD_W rising edges on ser_clk_o. The serial clock stays low outside them.
- R4: ser_clk_o first rises HALF_CYC system cycles after the accepting edge. After that it is high for HALF_CYC cycles and low for HALF_CYC cycles. ser_data_o changes only in the cycle in which ser_clk_o falls, never while it is high.
- R5: ser_latch_o rises HALF_CYC + GAP_CYC cycles after the last rising serial clock edge. It rises GAP_CYC cycles after the final fall.
- R6: Each transfer produces one ser_latch_o pulse of exactly STB_CYC cycles. ser_clk_o and ser_data_o are low for its whole width.
- R7: busy_o rises on the edge that accepts start_i and falls on the edge on which ser_latch_o falls. done_o is high for exactly that one following cycle.
- R8: A start_i sampled while busy_o is high is ignored. The word sent, the timing and the single latch pulse are unchanged, and busy_o stays low after the transfer if start_i is then low.
- R9: start_i held high makes transfers run back to back. A new transfer is accepted on the first edge after done_o, with the word present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer when idle |
| word_i | input | WORD_W | Parallel word captured on start |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at end of latch |
| ser_clk_o | output | 1 | Generated serial clock, idles low |
| ser_data_o | output | 1 | Serial data, LSB first, idles low |
| ser_latch_o | output | 1 | Latch pulse after the last bit |

## Verification
The assertions check on every cycle that the latch pulse is clean, with clock and data low, and that an idle block holds every line low. They also check that data never moves while the serial clock is high, and that the high phase, the gap before the latch and the latch width have their programmed lengths. DONE must coincide with the latch fall. Bit order, the count of rising edges, the absolute placement of the first edge and of the latch, the ignoring of a start during a transfer, and back-to-back operation under a held start can only be shown by the bench scenarios, which track whole frames.

// File: rtl/eqw_pkg.sv
package eqw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_LATCH
  } eqw_state_t;

  // system cycles needed to cover one microsecond, rounded up
  function automatic int unsigned cyc_per_us(input int unsigned hz);
    return (hz + 999_999) / 1_000_000;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/eqw_timer.sv
module eqw_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/eqw_shifter.sv
module eqw_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              shift,
  output logic              nxt_bit,
  output logic              last
);

  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sr;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= word;
      idx <= '0;
    end else if (shift) begin
      sr  <= sr >> 1;
      idx <= idx + IDX_W'(1);
    end
  end

  assign nxt_bit = sr[1];
  assign last    = (idx == IDX_W'(WORD_W - 1));

endmodule

// File: rtl/eqw_seq.sv
module eqw_seq
  import eqw_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int HALF_CYC = 125,
  parameter int GAP_CYC  = 125,
  parameter int STB_CYC  = 125
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             first_bit,
  input  logic             nxt_bit,
  input  logic             last,
  input  logic             expired,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  output logic             sr_load,
  output logic             sr_shift,
  output logic             ser_clk,
  output logic             ser_data,
  output logic             ser_latch,
  output logic             busy,
  output logic             done
);

  eqw_state_t state, nxt;

  always_comb begin
    nxt      = state;
    t_load   = 1'b0;
    t_val    = '0;
    sr_load  = 1'b0;
    sr_shift = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        nxt     = ST_LOW;
        t_load  = 1'b1;
        t_val   = CNT_W'(HALF_CYC - 1);
        sr_load = 1'b1;
      end
      ST_LOW: if (expired) begin
        nxt    = ST_HIGH;
        t_load = 1'b1;
        t_val  = CNT_W'(HALF_CYC - 1);
      end
      ST_HIGH: if (expired) begin
        t_load = 1'b1;
        if (last) begin
          nxt   = ST_GAP;
          t_val = CNT_W'(GAP_CYC - 1);
        end else begin
          nxt      = ST_LOW;
          t_val    = CNT_W'(HALF_CYC - 1);
          sr_shift = 1'b1;
        end
      end
      ST_GAP: if (expired) begin
        nxt    = ST_LATCH;
        t_load = 1'b1;
        t_val  = CNT_W'(STB_CYC - 1);
      end
      ST_LATCH: if (expired) begin
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // every output is a register decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ser_clk   <= 1'b0;
      ser_data  <= 1'b0;
      ser_latch <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= nxt;
      ser_clk   <= (nxt == ST_HIGH);
      ser_latch <= (nxt == ST_LATCH);
      busy      <= (nxt != ST_IDLE);
      done      <= (state == ST_LATCH) && (nxt == ST_IDLE);
      if (sr_load) begin
        ser_data <= first_bit;
      end else if (sr_shift) begin
        ser_data <= nxt_bit;
      end else if (nxt == ST_GAP || nxt == ST_IDLE) begin
        ser_data <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/eq_word_sender.sv
module eq_word_sender
  import eqw_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int SYS_HZ   = 125_000_000,
  parameter int HALF_CYC = 125,
  parameter int GAP_CYC  = 125,
  parameter int STB_CYC  = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ser_clk_o,
  output logic              ser_data_o,
  output logic              ser_latch_o
);

  localparam int unsigned MIN_CYC = cyc_per_us(SYS_HZ);
  localparam int unsigned MAX_CYC = max3(HALF_CYC, GAP_CYC, STB_CYC);
  localparam int          CNT_W   = $clog2(MAX_CYC + 1);

  // link limits: 1 us setup/hold per half period (also keeps clock <= 500 kHz),
  // 1 us latch width; the half period plus gap covers the clock-to-latch delay
  if (WORD_W < 2) begin : g_bad_width
    $error("WORD_W must be at least 2");
  end
  if (HALF_CYC < MIN_CYC) begin : g_bad_half
    $error("HALF_CYC too short for setup, hold and 500 kHz limit");
  end
  if (STB_CYC < MIN_CYC) begin : g_bad_latch
    $error("STB_CYC shorter than 1 us");
  end
  if (GAP_CYC < 1) begin : g_bad_gap
    $error("GAP_CYC must be at least 1");
  end

  logic             t_load, expired, sr_load, sr_shift, nxt_bit, last;
  logic [CNT_W-1:0] t_val;

  eqw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (expired)
  );

  eqw_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (sr_load),
    .word    (word_i),
    .shift   (sr_shift),
    .nxt_bit (nxt_bit),
    .last    (last)
  );

  eqw_seq #(
    .CNT_W    (CNT_W),
    .HALF_CYC (HALF_CYC),
    .GAP_CYC  (GAP_CYC),
    .STB_CYC  (STB_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .first_bit (word_i[0]),
    .nxt_bit   (nxt_bit),
    .last      (last),
    .expired   (expired),
    .t_load    (t_load),
    .t_val     (t_val),
    .sr_load   (sr_load),
    .sr_shift  (sr_shift),
    .ser_clk   (ser_clk_o),
    .ser_data  (ser_data_o),
    .ser_latch (ser_latch_o),
    .busy      (busy_o),
    .done      (done_o)
  );

endmodule

// File: rtl/eqw_checker.sv
module eqw_checker #(
  parameter int HALF_CYC = 125,
  parameter int GAP_CYC  = 125,
  parameter int STB_CYC  = 125
) (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic done_o,
  input logic ser_clk_o,
  input logic ser_data_o,
  input logic ser_latch_o
);

  int unsigned hi_cnt, lo_cnt, lt_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= 0;
      lo_cnt <= 0;
      lt_cnt <= 0;
    end else begin
      hi_cnt <= ser_clk_o ? hi_cnt + 1 : 0;
      lo_cnt <= ser_clk_o ? 0 : lo_cnt + 1;
      lt_cnt <= ser_latch_o ? lt_cnt + 1 : 0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!ser_clk_o && !ser_data_o && !ser_latch_o));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ser_clk_o |-> $stable(ser_data_o));

  // R4
  high_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_clk_o) |-> (hi_cnt == HALF_CYC));

  // R5
  gap_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_latch_o) |-> (lo_cnt == GAP_CYC));

  // R6
  latch_clean_chk: assert property (@(posedge clk) disable iff (rst)
    ser_latch_o |-> (!ser_clk_o && !ser_data_o));

  // R6
  latch_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_latch_o) |-> (lt_cnt == STB_CYC));

  // R7
  done_align_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!ser_latch_o && $past(ser_latch_o) && !busy_o));

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(ser_latch_o));

endmodule

bind eq_word_sender eqw_checker #(
  .HALF_CYC (HALF_CYC),
  .GAP_CYC  (GAP_CYC),
  .STB_CYC  (STB_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ser_clk_o   (ser_clk_o),
  .ser_data_o  (ser_data_o),
  .ser_latch_o (ser_latch_o)
);

// File: tb/eq_word_sender_test.sv
module eq_word_sender_test;

  localparam int W     = 8;
  localparam int HALF  = 125;
  localparam int GAP   = 125;
  localparam int STB   = 125;
  localparam int LIMIT = 20 * HALF + GAP + STB + 50;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] word = '0;
  logic         busy, done, sclk, sdata, latch;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  eq_word_sender #(
    .WORD_W   (W),
    .SYS_HZ   (125_000_000),
    .HALF_CYC (HALF),
    .GAP_CYC  (GAP),
    .STB_CYC  (STB)
  ) uut (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .word_i      (word),
    .busy_o      (busy),
    .done_o      (done),
    .ser_clk_o   (sclk),
    .ser_data_o  (sdata),
    .ser_latch_o (latch)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // present a word and pulse start; returns at the first negedge after acceptance
  task automatic launch(input logic [W-1:0] w, input bit hold);
    @(negedge clk);
    word  = w;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!hold) start = 1'b0;
  endtask

  // follow one frame, sampling at negedges; t=1 is the first negedge after acceptance
  task automatic watch(input logic [W-1:0] expw, input int inj_t, input logic [W-1:0] inj_w);
    int rises = 0, rise_t = -1, first_rise = -1, last_rise = -1;
    int spacing_bad = 0, high_bad = 0, data_bad = 0;
    int lt_rise = -1, lt_fall = -1, lt_rises = 0, lt_dirty = 0;
    int done_t = -1, busy_gap = 0;
    bit done_busy = 1'b0, busy1, pc = 1'b0, pl = 1'b0, pd;
    logic [W-1:0] got = '0;
    busy1 = busy;
    pd    = sdata;
    for (int t = 1; t <= LIMIT; t++) begin
      if (inj_t > 0 && t == inj_t) begin
        word  = inj_w;
        start = 1'b1;
      end else if (inj_t > 0 && t == inj_t + 1) begin
        start = 1'b0;
      end
      if (sclk && !pc) begin
        if (rises < W) got[rises] = sdata;
        if (rises > 0 && t - rise_t != 2 * HALF) spacing_bad++;
        if (first_rise < 0) first_rise = t;
        rise_t    = t;
        last_rise = t;
        rises++;
      end
      if (!sclk && pc && t - rise_t != HALF) high_bad++;
      if (sclk && pc && sdata != pd) data_bad++;
      if (latch && !pl) begin
        lt_rises++;
        lt_rise = t;
      end
      if (!latch && pl) lt_fall = t;
      if (latch && (sclk || sdata)) lt_dirty++;
      if (done) begin
        done_t    = t;
        done_busy = busy;
      end else if (!busy) begin
        busy_gap++;
      end
      pc = sclk;
      pl = latch;
      pd = sdata;
      if (done) break;
      @(negedge clk);
    end
    chk(busy1 == 1'b1, "R7", "busy after accept", int'(busy1), 1);
    chk(first_rise == HALF + 1, "R4", "first rise cycle", first_rise, HALF + 1);
    chk(rises == W, "R3", "rising edges", rises, W);
    chk(got == expw, "R2", "bits captured", int'(got), int'(expw));
    chk(spacing_bad == 0, "R4", "rise spacing errors", spacing_bad, 0);
    chk(high_bad == 0, "R4", "high phase errors", high_bad, 0);
    chk(data_bad == 0, "R4", "data moved while high", data_bad, 0);
    chk(lt_rise == last_rise + HALF + GAP, "R5", "latch rise cycle", lt_rise,
        last_rise + HALF + GAP);
    chk(lt_fall - lt_rise == STB, "R6", "latch width", lt_fall - lt_rise, STB);
    chk(lt_dirty == 0, "R6", "clock/data high in latch", lt_dirty, 0);
    chk(lt_rises == 1, "R8", "latch pulses", lt_rises, 1);
    chk(done_t == lt_fall, "R7", "done cycle", done_t, lt_fall);
    chk(done_busy == 1'b0, "R7", "busy at done", int'(done_busy), 0);
    chk(busy_gap == 0, "R7", "busy dropped early", busy_gap, 0);
  endtask

  task automatic after_frame();
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width", int'(done), 0);
    chk(busy == 1'b0, "R8", "busy after frame", int'(busy), 0);
    chk({sclk, sdata, latch} == 3'b000, "R1", "idle lines", int'({sclk, sdata, latch}), 0);
  endtask

  task automatic test_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({busy, done, sclk, sdata, latch} == 5'b0, "R1", "outputs in reset",
        int'({busy, done, sclk, sdata, latch}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, done, sclk, sdata, latch} == 5'b0, "R1", "outputs idle",
        int'({busy, done, sclk, sdata, latch}), 0);
  endtask

  task automatic test_frame(input logic [W-1:0] w);
    launch(w, 1'b0);
    watch(w, 0, '0);
    after_frame();
  endtask

  // R8: a second start during shifting or during the latch changes nothing
  task automatic test_ignore(input logic [W-1:0] w, input int at_t, input logic [W-1:0] other);
    launch(w, 1'b0);
    watch(w, at_t, other);
    after_frame();
  endtask

  // R9: start held high chains two frames
  task automatic test_back_to_back(input logic [W-1:0] w1, input logic [W-1:0] w2);
    launch(w1, 1'b1);
    watch(w1, 0, '0);
    word = w2;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy on chained start", int'(busy), 1);
    watch(w2, 0, '0);
    after_frame();
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    report();
    $finish;
  end

  initial begin
    test_reset();
    test_frame(8'hA5);
    test_frame(8'h00);
    test_frame(8'hFF);
    test_frame(8'h81);
    test_ignore(8'h3C, 600, 8'hFF);
    test_ignore(8'h5A, 15 * HALF + 1 + HALF + GAP + 5, 8'hC3);
    test_back_to_back(8'h96, 8'h69);
    report();
    $finish;
  end

endmodule